// File: doc/BRIEF.md
# Serial Channel Command and Status Register

This block is the control slice of one channel of a multi-channel serial controller. Software reaches it through a small byte-wide register window. A command byte carries four independent enable and disable bits for the receiver and transmitter, and a four-bit command code in its upper nibble. The block keeps the channel's 8-bit status byte and a bank of mode bytes. The mode bank is reached through a pointer that moves forward on every access and then stays on the last entry. The block also gates host writes to the transmit holding register.

The receive path reports into the status byte through set and clear pulses and one level input. Toward the block-level interrupt status, the block sends one-cycle set and clear requests that a neighbouring block merges. Writes to the clock-select and auxiliary addresses are accepted and dropped.

Register window (`addr_i`): 0 mode bank, 1 status (read) / clock select (write, ignored), 2 command, 3 transmit holding, 4 to 7 auxiliary (ignored). Status byte: bit 0 receive ready, 1 receive FIFO full, 2 transmit ready, 3 transmitter empty, 4 overrun, 5 parity error, 6 framing error, 7 received break.

Top module: `sio_chan_ctl`

## Requirements
- R1: After reset the status byte, all mode entries and the mode pointer are zero, the receiver and transmitter are disabled, and no strobe or interrupt request is active.
- R2: Command bit 0 enables the receiver and bit 1 disables it. When both are set in one write, the receiver ends disabled.
- R3: Command bit 2 sets status bits 2 and 3 and pulses `isr_txrdy_set_o`. Command bit 3 clears both bits and pulses `isr_txrdy_clr_o`. When both are set in one write, the transmitter ends disabled.
- R4: Command code 3 clears status bits 2 and 3 and pulses `isr_txrdy_clr_o`, even when bit 2 is set in the same write.
- R5: Command code 2 disables the receiver, clears status bit 0 and pulses `isr_rxrdy_clr_o`.
- R6: Command code 4 clears status bits 7 to 4 and leaves bits 3 to 0 unchanged.
- R7: Command code 5 pulses `isr_brk_clr_o` for one cycle and leaves the status byte unchanged.
- R8: Command code 0 and codes 6 to 15 change neither the status byte nor the receiver enable, and raise no request.
- R9: A mode write stores the data into the entry the pointer selects, and a mode read returns that entry. After either access the pointer advances and then stays on the last entry. Only command code 1 returns the pointer to 0.
- R10: A write to the holding address produces a one-cycle `tx_strobe_o` carrying the data only when status bit 2 is set. Otherwise the write is dropped.
- R11: `rxrdy_set_i` sets status bit 0 and `rxrdy_clr_i` clears it. Bit 1 follows `ffull_i`. `err_set_i[3:0]` pulses set status bits 7 to 4, which stay set until cleared. A read at address 1 returns the status byte.
- R12: Writes to addresses 1 and 4 to 7 change no status, mode or enable state and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write |
| rd_en_i | input | 1 | Register read |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data (combinational) |
| rxrdy_set_i | input | 1 | Receive data available pulse |
| rxrdy_clr_i | input | 1 | Receive FIFO drained pulse |
| ffull_i | input | 1 | Receive FIFO full level |
| err_set_i | input | 4 | Overrun, parity, framing, break set pulses (bits 0 to 3) |
| status_o | output | 8 | Channel status byte |
| mode_o | output | 16 | Mode entries, entry n at bits [8n+7:8n] |
| rx_en_o | output | 1 | Receiver enabled |
| tx_strobe_o | output | 1 | Transmit data valid pulse |
| tx_data_o | output | 8 | Transmit data |
| isr_txrdy_set_o | output | 1 | Request to set the channel's transmit-ready interrupt bit |
| isr_txrdy_clr_o | output | 1 | Request to clear the channel's transmit-ready interrupt bit |
| isr_rxrdy_clr_o | output | 1 | Request to clear the channel's receive-ready interrupt bit |
| isr_brk_clr_o | output | 1 | Request to clear both break-change interrupt bits |

## Verification
The bench targets writes that combine conflicting bits. A design that let enable win when enable and disable share a byte would leave the receiver or transmitter on. A design that applied the reset-transmitter code before the enable bit would raise transmit ready when it should stay clear. The bench checks that the mode pointer stays on the last entry after a third access and returns to 0 only on command code 1. A design that wrapped the pointer, or reset it on some other command, would return the wrong byte. It also writes the holding register while the transmitter is off, writes to the auxiliary addresses, and sends every unused command code, so any stray decode would show up as a strobe, a pulse or a change in status.

// File: rtl/sio_chan_pkg.sv
package sio_chan_pkg;
  localparam int DW = 8;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_MODE = 3'd0;
  localparam logic [AW-1:0] A_STAT = 3'd1;
  localparam logic [AW-1:0] A_CMD  = 3'd2;
  localparam logic [AW-1:0] A_HOLD = 3'd3;

  localparam logic [3:0] C_RST_PTR = 4'd1;
  localparam logic [3:0] C_RST_RX  = 4'd2;
  localparam logic [3:0] C_RST_TX  = 4'd3;
  localparam logic [3:0] C_RST_ERR = 4'd4;
  localparam logic [3:0] C_RST_BRK = 4'd5;

  localparam int S_RXRDY = 0;
  localparam int S_FFULL = 1;
  localparam int S_TXRDY = 2;
  localparam int S_TXEMT = 3;
  localparam int S_ERRLO = 4;
endpackage

// File: rtl/sio_cmd_decode.sv
module sio_cmd_decode
  import sio_chan_pkg::*;
(
  input  logic          wr_i,
  input  logic [DW-1:0] cmd_i,
  output logic          rx_on_o,
  output logic          rx_off_o,
  output logic          tx_on_o,
  output logic          tx_off_o,
  output logic          rst_ptr_o,
  output logic          rst_rx_o,
  output logic          rst_tx_o,
  output logic          rst_err_o,
  output logic          rst_brk_o
);
  logic [3:0] code;
  assign code = cmd_i[7:4];

  always_comb begin
    rx_on_o   = wr_i & cmd_i[0];
    rx_off_o  = wr_i & cmd_i[1];
    tx_on_o   = wr_i & cmd_i[2];
    tx_off_o  = wr_i & cmd_i[3];
    rst_ptr_o = wr_i & (code == C_RST_PTR);
    rst_rx_o  = wr_i & (code == C_RST_RX);
    rst_tx_o  = wr_i & (code == C_RST_TX);
    rst_err_o = wr_i & (code == C_RST_ERR);
    rst_brk_o = wr_i & (code == C_RST_BRK);
  end
endmodule

// File: rtl/sio_status_reg.sv
module sio_status_reg
  import sio_chan_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_on_i,
  input  logic          rx_off_i,
  input  logic          tx_on_i,
  input  logic          tx_off_i,
  input  logic          rst_rx_i,
  input  logic          rst_tx_i,
  input  logic          rst_err_i,
  input  logic          rst_brk_i,
  input  logic          rxrdy_set_i,
  input  logic          rxrdy_clr_i,
  input  logic          ffull_i,
  input  logic [3:0]    err_set_i,
  output logic [DW-1:0] status_o,
  output logic          rx_en_o,
  output logic          txrdy_set_o,
  output logic          txrdy_clr_o,
  output logic          rxrdy_clr_o,
  output logic          brk_clr_o
);
  logic          tx_up, tx_down;
  logic [DW-1:0] st_d;
  logic          rx_en_d;

  // enable first, then disable, then command code: later actions win
  assign tx_down = tx_off_i | rst_tx_i;
  assign tx_up   = tx_on_i & ~tx_down;

  always_comb begin
    st_d = status_o;
    if (rst_rx_i || rxrdy_clr_i) st_d[S_RXRDY] = 1'b0;
    else if (rxrdy_set_i)        st_d[S_RXRDY] = 1'b1;
    st_d[S_FFULL] = ffull_i;
    if (tx_up)   {st_d[S_TXEMT], st_d[S_TXRDY]} = 2'b11;
    if (tx_down) {st_d[S_TXEMT], st_d[S_TXRDY]} = 2'b00;
    if (rst_err_i) st_d[DW-1:S_ERRLO] = '0;
    else           st_d[DW-1:S_ERRLO] = status_o[DW-1:S_ERRLO] | err_set_i;

    rx_en_d = rx_en_o;
    if (rx_on_i)              rx_en_d = 1'b1;
    if (rx_off_i || rst_rx_i) rx_en_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_o    <= '0;
      rx_en_o     <= 1'b0;
      txrdy_set_o <= 1'b0;
      txrdy_clr_o <= 1'b0;
      rxrdy_clr_o <= 1'b0;
      brk_clr_o   <= 1'b0;
    end else begin
      status_o    <= st_d;
      rx_en_o     <= rx_en_d;
      txrdy_set_o <= tx_up;
      txrdy_clr_o <= tx_down;
      rxrdy_clr_o <= rst_rx_i;
      brk_clr_o   <= rst_brk_i;
    end
  end

  // R3
  tx_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_on_i && !tx_off_i && !rst_tx_i) |=> (status_o[S_TXEMT:S_TXRDY] == 2'b11));
  // R4
  tx_clr_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txrdy_clr_o |-> !status_o[S_TXRDY] && !txrdy_set_o);
  // R6
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_err_i |=> (status_o[DW-1:S_ERRLO] == '0));
  // R2
  rx_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_off_i || rst_rx_i) |=> !rx_en_o);
endmodule

// File: rtl/sio_mode_bank.sv
module sio_mode_bank
  import sio_chan_pkg::*;
#(
  parameter int MODE_DEPTH = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic                     rd_i,
  input  logic [DW-1:0]            wdata_i,
  input  logic                     ptr_rst_i,
  output logic [DW-1:0]            rdata_o,
  output logic [MODE_DEPTH*DW-1:0] mode_o
);
  localparam int PW = (MODE_DEPTH > 1) ? $clog2(MODE_DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(MODE_DEPTH - 1);

  logic [MODE_DEPTH-1:0][DW-1:0] ent;
  logic [PW-1:0]                 ptr;

  for (genvar g = 0; g < MODE_DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     ent[g] <= '0;
      else if (wr_i && ptr == PW'(g))  ent[g] <= wdata_i;
    end
    assign mode_o[g*DW +: DW] = ent[g];
  end

  assign rdata_o = ent[ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             ptr <= '0;
    else if (ptr_rst_i)                      ptr <= '0;
    else if ((wr_i || rd_i) && ptr != LAST)  ptr <= ptr + 1'b1;
  end

  // R9
  ptr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr != '0 && !ptr_rst_i) |=> (ptr != '0));
  // R9
  ptr_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_i || rd_i) && !ptr_rst_i && MODE_DEPTH > 1) |=> (ptr != '0));
endmodule

// File: rtl/sio_tx_gate.sv
module sio_tx_gate
  import sio_chan_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          txrdy_i,
  output logic          strobe_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_o <= 1'b0;
      data_o   <= '0;
    end else begin
      strobe_o <= wr_i & txrdy_i;
      if (wr_i && txrdy_i) data_o <= wdata_i;
    end
  end

  // R10
  tx_blocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !txrdy_i) |=> !strobe_o);
  // R10
  tx_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && txrdy_i) |=> strobe_o && (data_o == $past(wdata_i)));
endmodule

// File: rtl/sio_chan_ctl.sv
module sio_chan_ctl
  import sio_chan_pkg::*;
#(
  parameter int MODE_DEPTH = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic                     rd_en_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rd_data_o,
  input  logic                     rxrdy_set_i,
  input  logic                     rxrdy_clr_i,
  input  logic                     ffull_i,
  input  logic [3:0]               err_set_i,
  output logic [DW-1:0]            status_o,
  output logic [MODE_DEPTH*DW-1:0] mode_o,
  output logic                     rx_en_o,
  output logic                     tx_strobe_o,
  output logic [DW-1:0]            tx_data_o,
  output logic                     isr_txrdy_set_o,
  output logic                     isr_txrdy_clr_o,
  output logic                     isr_rxrdy_clr_o,
  output logic                     isr_brk_clr_o
);
  logic rx_on, rx_off, tx_on, tx_off;
  logic rst_ptr, rst_rx, rst_tx, rst_err, rst_brk;
  logic [DW-1:0] mode_rdata;

  logic sel_mode, sel_cmd, sel_hold;
  assign sel_mode = (addr_i == A_MODE);
  assign sel_cmd  = (addr_i == A_CMD);
  assign sel_hold = (addr_i == A_HOLD);

  sio_cmd_decode u_dec (
    .wr_i     (wr_en_i & sel_cmd),
    .cmd_i    (wdata_i),
    .rx_on_o  (rx_on),
    .rx_off_o (rx_off),
    .tx_on_o  (tx_on),
    .tx_off_o (tx_off),
    .rst_ptr_o(rst_ptr),
    .rst_rx_o (rst_rx),
    .rst_tx_o (rst_tx),
    .rst_err_o(rst_err),
    .rst_brk_o(rst_brk)
  );

  sio_status_reg u_stat (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rx_on_i    (rx_on),
    .rx_off_i   (rx_off),
    .tx_on_i    (tx_on),
    .tx_off_i   (tx_off),
    .rst_rx_i   (rst_rx),
    .rst_tx_i   (rst_tx),
    .rst_err_i  (rst_err),
    .rst_brk_i  (rst_brk),
    .rxrdy_set_i(rxrdy_set_i),
    .rxrdy_clr_i(rxrdy_clr_i),
    .ffull_i    (ffull_i),
    .err_set_i  (err_set_i),
    .status_o   (status_o),
    .rx_en_o    (rx_en_o),
    .txrdy_set_o(isr_txrdy_set_o),
    .txrdy_clr_o(isr_txrdy_clr_o),
    .rxrdy_clr_o(isr_rxrdy_clr_o),
    .brk_clr_o  (isr_brk_clr_o)
  );

  sio_mode_bank #(.MODE_DEPTH(MODE_DEPTH)) u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i & sel_mode),
    .rd_i     (rd_en_i & sel_mode),
    .wdata_i  (wdata_i),
    .ptr_rst_i(rst_ptr),
    .rdata_o  (mode_rdata),
    .mode_o   (mode_o)
  );

  sio_tx_gate u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i & sel_hold),
    .wdata_i (wdata_i),
    .txrdy_i (status_o[S_TXRDY]),
    .strobe_o(tx_strobe_o),
    .data_o  (tx_data_o)
  );

  always_comb begin
    unique case (addr_i)
      A_MODE:  rd_data_o = mode_rdata;
      A_STAT:  rd_data_o = status_o;
      default: rd_data_o = '0;
    endcase
  end

  // R12
  aux_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !rd_en_i && addr_i[2]) |=> !tx_strobe_o && !isr_txrdy_set_o && !isr_brk_clr_o);
endmodule

// File: tb/sio_chan_ctl_test.sv
`timescale 1ns/1ps
module sio_chan_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rd_data;
  logic        rxrdy_set = 1'b0, rxrdy_clr = 1'b0, ffull = 1'b0;
  logic [3:0]  err_set = '0;
  logic [7:0]  status;
  logic [15:0] mode;
  logic        rx_en, tx_strobe;
  logic [7:0]  tx_data;
  logic        txs, txc, rxc, brkc;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  sio_chan_ctl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rd_data_o(rd_data),
    .rxrdy_set_i(rxrdy_set), .rxrdy_clr_i(rxrdy_clr), .ffull_i(ffull),
    .err_set_i(err_set), .status_o(status), .mode_o(mode), .rx_en_o(rx_en),
    .tx_strobe_o(tx_strobe), .tx_data_o(tx_data),
    .isr_txrdy_set_o(txs), .isr_txrdy_clr_o(txc),
    .isr_rxrdy_clr_o(rxc), .isr_brk_clr_o(brkc)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, results sampled one negedge later
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = '0; #1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1; d = rd_data;
    @(negedge clk); rd_en = 1'b0; addr = '0; #1;
  endtask

  function automatic logic [3:0] pulses();
    return {txs, txc, rxc, brkc};
  endfunction

  task automatic t_reset;
    chk("R1", "status", status, 8'h00);
    chk("R1", "rx_en", rx_en, 1'b0);
    chk("R1", "mode", mode, 16'h0000);
    chk("R1", "strobe", tx_strobe, 1'b0);
    chk("R1", "pulses", pulses(), 4'h0);
  endtask

  task automatic t_hold_blocked;
    wr(3'd3, 8'h55);
    chk("R10", "strobe while tx off", tx_strobe, 1'b0);
  endtask

  task automatic t_rx_bits;
    wr(3'd2, 8'h01); chk("R2", "rx on", rx_en, 1'b1);
    wr(3'd2, 8'h03); chk("R2", "on+off", rx_en, 1'b0);
    wr(3'd2, 8'h01); wr(3'd2, 8'h02); chk("R2", "rx off", rx_en, 1'b0);
  endtask

  task automatic t_tx_bits;
    wr(3'd2, 8'h04);
    chk("R3", "status tx on", status, 8'h0C);
    chk("R3", "pulses tx on", pulses(), 4'b1000);
    wr(3'd3, 8'h5A);
    chk("R10", "strobe", tx_strobe, 1'b1);
    chk("R10", "data", tx_data, 8'h5A);
    @(negedge clk); #1;
    chk("R10", "strobe one cycle", tx_strobe, 1'b0);
    wr(3'd2, 8'h0C);
    chk("R3", "status on+off", status, 8'h00);
    chk("R3", "pulses on+off", pulses(), 4'b0100);
    wr(3'd2, 8'h04); wr(3'd2, 8'h08);
    chk("R3", "status tx off", status, 8'h00);
  endtask

  task automatic t_reset_tx;
    wr(3'd2, 8'h04);
    wr(3'd2, 8'h34);
    chk("R4", "status", status, 8'h00);
    chk("R4", "pulses", pulses(), 4'b0100);
  endtask

  task automatic t_status_in;
    logic [7:0] d;
    @(negedge clk); rxrdy_set = 1'b1; ffull = 1'b1; err_set = 4'b1010;
    @(negedge clk); rxrdy_set = 1'b0; err_set = '0; #1;
    chk("R11", "set inputs", status, 8'hA3);
    @(negedge clk); #1;
    chk("R11", "errors sticky", status, 8'hA3);
    @(negedge clk); rxrdy_clr = 1'b1;
    @(negedge clk); rxrdy_clr = 1'b0; #1;
    chk("R11", "rxrdy clear", status, 8'hA2);
    @(negedge clk); rxrdy_set = 1'b1;
    @(negedge clk); rxrdy_set = 1'b0; #1;
    rd(3'd1, d);
    chk("R11", "status read", d, 8'hA3);
  endtask

  task automatic t_reset_err;
    wr(3'd2, 8'h04);
    chk("R6", "pre", status, 8'hAF);
    wr(3'd2, 8'h40);
    chk("R6", "after", status, 8'h0F);
  endtask

  task automatic t_reset_rx;
    wr(3'd2, 8'h01);
    wr(3'd2, 8'h20);
    chk("R5", "rx_en", rx_en, 1'b0);
    chk("R5", "status", status, 8'h0E);
    chk("R5", "pulses", pulses(), 4'b0010);
  endtask

  task automatic t_brk;
    wr(3'd2, 8'h50);
    chk("R7", "pulses", pulses(), 4'b0001);
    chk("R7", "status", status, 8'h0E);
    @(negedge clk); #1;
    chk("R7", "one cycle", brkc, 1'b0);
  endtask

  task automatic t_unused_codes;
    wr(3'd2, 8'h01);
    for (int c = 0; c < 16; c++) begin
      if (c >= 1 && c <= 5) continue;
      wr(3'd2, {c[3:0], 4'h0});
      chk("R8", $sformatf("code %0d status", c), status, 8'h0E);
      chk("R8", $sformatf("code %0d rx", c), rx_en, 1'b1);
      chk("R8", $sformatf("code %0d pulses", c), pulses(), 4'h0);
    end
  endtask

  task automatic t_aux;
    logic [2:0] al [5] = '{3'd1, 3'd4, 3'd5, 3'd6, 3'd7};
    for (int i = 0; i < 5; i++) begin
      wr(al[i], 8'hFF);
      chk("R12", "status", status, 8'h0E);
      chk("R12", "rx_en", rx_en, 1'b1);
      chk("R12", "mode", mode, 16'h0000);
      chk("R12", "strobe", tx_strobe, 1'b0);
    end
  endtask

  task automatic t_mode;
    logic [7:0] d;
    wr(3'd0, 8'hA5); wr(3'd0, 8'h3C);
    chk("R9", "two writes", mode, 16'h3CA5);
    wr(3'd0, 8'h77);
    chk("R9", "sticky write", mode, 16'h77A5);
    rd(3'd0, d); chk("R9", "read at ptr 1", d, 8'h77);
    wr(3'd2, 8'h10);
    rd(3'd0, d); chk("R9", "read after ptr reset", d, 8'hA5);
    rd(3'd0, d); chk("R9", "read advanced", d, 8'h77);
    wr(3'd2, 8'h40);
    rd(3'd0, d); chk("R9", "other code keeps ptr", d, 8'h77);
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset;
    t_hold_blocked;
    t_rx_bits;
    t_tx_bits;
    t_reset_tx;
    t_status_in;
    t_reset_err;
    t_reset_rx;
    t_brk;
    t_unused_codes;
    t_aux;
    t_mode;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule